// File: doc/BRIEF.md
# Sectored Cache Line-Fill Controller

This block runs the lookup, fill and state update of a two-way set-associative cache whose entries are sectors. A sector holds one address tag for a pair of 32-byte lines. Each line has its own two-bit coherence state (Invalid, Shared, Exclusive, Modified). The caller presents the address of one line. The controller classifies the access as a hit, a tag-miss fill or a tag-hit fill and reports that outcome with the way and the line's prior state.

On a fill it sends a burst request for the line to the next memory level. It forwards the four returned 64-bit beats to the data-array write port. After the last beat it marks the line valid. When the caller allows prefetch, the other line of the sector is requested straight afterwards as a second burst, unless that line already holds data.

Two lines share a single tag, so the two fill kinds treat the neighbouring line differently. Installing a new tag discards whatever the sector held. Filling a missing line under a matching tag leaves its neighbour untouched.

Top module: `sectored_fill_unit`

## Requirements
- R1: Out of reset every line of every sector is Invalid and every set's replacement bit selects way 0. The controller is idle with `reqReady` high and `respValid` and `memReqValid` low, so the first access to any set is a tag-miss fill into way 0.
- R2: One cycle after a request is accepted, `respValid` pulses with `respKind`: 0 for a hit, 1 for a tag-miss fill, 2 for a tag-hit fill. It also gives `respWay` and `respState`, which is the requested line's state before the access, or 0 when no tag matched. A tag matches only if at least one line of that sector is not Invalid.
- R3: A tag-miss fill writes the new tag into the victim way and sets both lines of that sector to Invalid. A later access to the other line of that sector is therefore a tag-hit fill, not a hit.
- R4: A tag-hit fill changes only the requested line. The other line of the sector keeps its state.
- R5: For each line fill, `memReqValid` rises with `memReqAddr` equal to the line's byte address (bits 4:0 zero, bit 5 the line within the sector). It holds until `memReqReady`. Each of the next four `memBeatValid` beats is passed to the data port with `dataWe` high, the set, the way, the line and the beat number 0 to 3 in arrival order.
- R6: A line becomes valid only on its fourth beat. `reqReady` stays low from acceptance until the fill sequence ends.
- R7: A filled line takes Exclusive (2), or Shared (1) when `memShared` is high together with the fourth beat. `memShared` on earlier beats has no effect.
- R8: With `reqPrefetch` set on the access, if the other line of the sector is Invalid when the first fill's fourth beat arrives, a second request for that line is raised in the very next cycle and filled the same way.
- R9: The prefetch is skipped, and the controller returns to idle, when prefetch was not requested or when the other line is already valid.
- R10: Each set keeps one replacement bit. A hit or a completed fill points it at the other way, and a tag-miss fill uses the way it points at.
- R11: A hit returns the controller to idle in the cycle after the report. The acceptance of a request is always followed one cycle later by the `respValid` report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request |
| reqLineAddr | input | ADDR_W-5 | Address of the requested 32-byte line (byte address bits above 4) |
| reqPrefetch | input | 1 | Allow prefetch of the other line of the sector |
| reqReady | output | 1 | Controller idle, request accepted when reqValid is high |
| respValid | output | 1 | Lookup outcome valid |
| respKind | output | 2 | 0 hit, 1 tag-miss fill, 2 tag-hit fill |
| respWay | output | 1 | Way hit or chosen for the fill |
| respState | output | 2 | Prior state of the requested line |
| memReqValid | output | 1 | Burst read request |
| memReqAddr | output | ADDR_W | Line-aligned byte address of the burst |
| memReqReady | input | 1 | Burst request accepted |
| memBeatValid | input | 1 | Returned beat valid |
| memBeatData | input | BEAT_W | Returned beat data |
| memShared | input | 1 | Line returned as shared, taken with the last beat |
| dataWe | output | 1 | Data-array write strobe |
| dataSet | output | log2(SETS) | Data-array set |
| dataWay | output | 1 | Data-array way |
| dataLine | output | 1 | Line within the sector |
| dataBeat | output | 2 | Beat within the line |
| dataWdata | output | BEAT_W | Data written |

## Verification
The embedded checks assume that the memory side never sends a beat before its burst request has been accepted and never sends more than four beats per request. They also assume that `reqValid` is only raised while `reqReady` is high. The bench drives the memory side as a well-behaved responder. It randomises only the acceptance delay, the gaps between beats and the `memShared` level on non-final beats. It issues a new access only once the controller has returned to idle. The random phase draws from a few tags over a few sets, so hits, tag-hit fills, evictions and skipped prefetches all occur often.

// File: rtl/sector_fill_pkg.sv
package sector_fill_pkg;

  typedef enum logic [1:0] {
    MESI_I = 2'd0,
    MESI_S = 2'd1,
    MESI_E = 2'd2,
    MESI_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    KIND_HIT     = 2'd0,
    KIND_TAGMISS = 2'd1,
    KIND_TAGHIT  = 2'd2
  } kind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic latchReq;
    logic latchWay;
    logic installTag;
    logic touchLru;
    logic fillLine;
    logic flipLine;
    logic beatClr;
    logic beatInc;
  } fill_strobe_t;

endpackage

// File: rtl/sector_fill_dp.sv
module sector_fill_dp
  import sector_fill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int BEAT_W = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fill_strobe_t               stb,
  input  logic [ADDR_W-6:0]          reqLineAddr,
  input  logic                       reqPrefetch,
  input  logic                       memShared,
  input  logic [BEAT_W-1:0]          memBeatData,
  output logic                       tagMatch,
  output logic                       reqLineValid,
  output logic                       otherLineValid,
  output logic                       beatLast,
  output logic                       pfEn,
  output logic                       respWay,
  output logic [1:0]                 respState,
  output logic [ADDR_W-1:0]          memReqAddr,
  output logic [$clog2(SETS)-1:0]    dataSet,
  output logic                       dataWay,
  output logic                       dataLine,
  output logic [1:0]                 dataBeat,
  output logic [BEAT_W-1:0]          dataWdata
);

  localparam int OFF_W = 5;
  localparam int SET_W = $clog2(SETS);
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LA_W - 1 - SET_W;
  localparam int WAYS  = 2;

  logic [TAG_W-1:0] tagArr   [SETS][WAYS];
  logic [1:0]       stateArr [SETS][WAYS][2];
  logic             lruArr   [SETS];

  logic [TAG_W-1:0] curTag;
  logic [SET_W-1:0] curSet;
  logic             curLine;
  logic             curWay;
  logic [1:0]       beatCnt;

  logic [WAYS-1:0]  sectorLive;
  logic [WAYS-1:0]  wayMatch;
  logic             matchWay;
  logic             lookWay;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign sectorLive[w] = (stateArr[curSet][w][0] != MESI_I) ||
                           (stateArr[curSet][w][1] != MESI_I);
    assign wayMatch[w]   = sectorLive[w] && (tagArr[curSet][w] == curTag);
  end

  assign tagMatch       = |wayMatch;
  assign matchWay       = wayMatch[1];
  assign lookWay        = tagMatch ? matchWay : lruArr[curSet];
  assign reqLineValid   = tagMatch && (stateArr[curSet][matchWay][curLine] != MESI_I);
  assign respWay        = lookWay;
  assign respState      = tagMatch ? stateArr[curSet][matchWay][curLine] : MESI_I;
  assign otherLineValid = stateArr[curSet][curWay][~curLine] != MESI_I;
  assign beatLast       = beatCnt == 2'd3;

  assign memReqAddr = {curTag, curSet, curLine, {OFF_W{1'b0}}};
  assign dataSet    = curSet;
  assign dataWay    = curWay;
  assign dataLine   = curLine;
  assign dataBeat   = beatCnt;
  assign dataWdata  = memBeatData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lruArr[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) begin
          tagArr[s][w]      <= '0;
          stateArr[s][w][0] <= MESI_I;
          stateArr[s][w][1] <= MESI_I;
        end
      end
      curTag  <= '0;
      curSet  <= '0;
      curLine <= 1'b0;
      curWay  <= 1'b0;
      pfEn    <= 1'b0;
      beatCnt <= 2'd0;
    end else begin
      if (stb.latchReq) begin
        curTag  <= reqLineAddr[LA_W-1 -: TAG_W];
        curSet  <= reqLineAddr[SET_W:1];
        curLine <= reqLineAddr[0];
        pfEn    <= reqPrefetch;
      end
      if (stb.latchWay) curWay <= lookWay;
      if (stb.installTag) begin
        tagArr[curSet][lookWay]      <= curTag;
        stateArr[curSet][lookWay][0] <= MESI_I;
        stateArr[curSet][lookWay][1] <= MESI_I;
      end
      if (stb.touchLru) lruArr[curSet] <= ~lookWay;
      if (stb.fillLine) begin
        stateArr[curSet][curWay][curLine] <= memShared ? MESI_S : MESI_E;
        lruArr[curSet] <= ~curWay;
      end
      if (stb.flipLine) curLine <= ~curLine;
      if (stb.beatClr)      beatCnt <= 2'd0;
      else if (stb.beatInc) beatCnt <= beatCnt + 2'd1;
    end
  end

  // R6
  state_on_last_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fillLine |-> beatCnt == 2'd3);

  // R3
  install_clears_sector_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.installTag |=> (stateArr[curSet][curWay][0] == MESI_I) &&
                       (stateArr[curSet][curWay][1] == MESI_I));

  // R10
  lru_points_away_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.touchLru |=> lruArr[curSet] != curWay);

endmodule

// File: rtl/sector_fill_ctl.sv
module sector_fill_ctl
  import sector_fill_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memReqReady,
  input  logic         memBeatValid,
  input  logic         tagMatch,
  input  logic         reqLineValid,
  input  logic         otherLineValid,
  input  logic         beatLast,
  input  logic         pfEn,
  output logic         reqReady,
  output logic         respValid,
  output logic [1:0]   respKind,
  output logic         memReqValid,
  output logic         dataWe,
  output fill_strobe_t stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_REQ, ST_BEAT} ctl_state_e;

  ctl_state_e curSt, nxtSt;
  logic       pfDone, pfDoneNxt;

  assign reqReady    = curSt == ST_IDLE;
  assign respValid   = curSt == ST_LOOK;
  assign memReqValid = curSt == ST_REQ;
  assign dataWe      = (curSt == ST_BEAT) && memBeatValid;

  always_comb begin
    nxtSt     = curSt;
    pfDoneNxt = pfDone;
    stb       = '0;
    respKind  = KIND_HIT;
    unique case (curSt)
      ST_IDLE: begin
        if (reqValid) begin
          stb.latchReq = 1'b1;
          nxtSt        = ST_LOOK;
        end
      end
      ST_LOOK: begin
        stb.latchWay = 1'b1;
        pfDoneNxt    = 1'b0;
        if (reqLineValid) begin
          respKind     = KIND_HIT;
          stb.touchLru = 1'b1;
          nxtSt        = ST_IDLE;
        end else if (tagMatch) begin
          respKind = KIND_TAGHIT;
          nxtSt    = ST_REQ;
        end else begin
          respKind       = KIND_TAGMISS;
          stb.installTag = 1'b1;
          nxtSt          = ST_REQ;
        end
      end
      ST_REQ: begin
        if (memReqReady) begin
          stb.beatClr = 1'b1;
          nxtSt       = ST_BEAT;
        end
      end
      ST_BEAT: begin
        if (memBeatValid) begin
          stb.beatInc = 1'b1;
          if (beatLast) begin
            stb.fillLine = 1'b1;
            if (pfEn && !pfDone && !otherLineValid) begin
              stb.flipLine = 1'b1;
              pfDoneNxt    = 1'b1;
              nxtSt        = ST_REQ;
            end else begin
              nxtSt = ST_IDLE;
            end
          end
        end
      end
      default: nxtSt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSt  <= ST_IDLE;
      pfDone <= 1'b0;
    end else begin
      curSt  <= nxtSt;
      pfDone <= pfDoneNxt;
    end
  end

  // R5
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R11
  accept_then_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> respValid);

endmodule

// File: rtl/sectored_fill_unit.sv
module sectored_fill_unit
  import sector_fill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int BEAT_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ADDR_W-6:0]       reqLineAddr,
  input  logic                    reqPrefetch,
  output logic                    reqReady,
  output logic                    respValid,
  output logic [1:0]              respKind,
  output logic                    respWay,
  output logic [1:0]              respState,
  output logic                    memReqValid,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memReqReady,
  input  logic                    memBeatValid,
  input  logic [BEAT_W-1:0]       memBeatData,
  input  logic                    memShared,
  output logic                    dataWe,
  output logic [$clog2(SETS)-1:0] dataSet,
  output logic                    dataWay,
  output logic                    dataLine,
  output logic [1:0]              dataBeat,
  output logic [BEAT_W-1:0]       dataWdata
);

  fill_strobe_t stb;
  logic tagMatch, reqLineValid, otherLineValid, beatLast, pfEn;

  sector_fill_ctl u_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .memReqReady    (memReqReady),
    .memBeatValid   (memBeatValid),
    .tagMatch       (tagMatch),
    .reqLineValid   (reqLineValid),
    .otherLineValid (otherLineValid),
    .beatLast       (beatLast),
    .pfEn           (pfEn),
    .reqReady       (reqReady),
    .respValid      (respValid),
    .respKind       (respKind),
    .memReqValid    (memReqValid),
    .dataWe         (dataWe),
    .stb            (stb)
  );

  sector_fill_dp #(
    .ADDR_W (ADDR_W),
    .SETS   (SETS),
    .BEAT_W (BEAT_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .reqLineAddr    (reqLineAddr),
    .reqPrefetch    (reqPrefetch),
    .memShared      (memShared),
    .memBeatData    (memBeatData),
    .tagMatch       (tagMatch),
    .reqLineValid   (reqLineValid),
    .otherLineValid (otherLineValid),
    .beatLast       (beatLast),
    .pfEn           (pfEn),
    .respWay        (respWay),
    .respState      (respState),
    .memReqAddr     (memReqAddr),
    .dataSet        (dataSet),
    .dataWay        (dataWay),
    .dataLine       (dataLine),
    .dataBeat       (dataBeat),
    .dataWdata      (dataWdata)
  );

endmodule

// File: tb/tb_sectored_fill_unit.sv
module tb_sectored_fill_unit;

  localparam int ADDR_W = 32;
  localparam int SETS   = 16;
  localparam int BEAT_W = 64;
  localparam int SET_W  = $clog2(SETS);
  localparam int LA_W   = ADDR_W - 5;
  localparam int TAG_W  = LA_W - 1 - SET_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [LA_W-1:0] reqLineAddr = '0;
  logic reqPrefetch = 1'b0;
  logic reqReady, respValid, respWay;
  logic [1:0] respKind, respState;
  logic memReqValid;
  logic [ADDR_W-1:0] memReqAddr;
  logic memReqReady = 1'b0;
  logic memBeatValid = 1'b0;
  logic [BEAT_W-1:0] memBeatData = '0;
  logic memShared = 1'b0;
  logic dataWe, dataWay, dataLine;
  logic [SET_W-1:0] dataSet;
  logic [1:0] dataBeat;
  logic [BEAT_W-1:0] dataWdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [TAG_W-1:0] mTag [SETS][2];
  logic [1:0]       mSt  [SETS][2][2];
  logic             mLru [SETS];

  always #4 clk = ~clk;

  sectored_fill_unit #(.ADDR_W(ADDR_W), .SETS(SETS), .BEAT_W(BEAT_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLineAddr(reqLineAddr),
    .reqPrefetch(reqPrefetch), .reqReady(reqReady), .respValid(respValid),
    .respKind(respKind), .respWay(respWay), .respState(respState),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memBeatValid(memBeatValid), .memBeatData(memBeatData), .memShared(memShared),
    .dataWe(dataWe), .dataSet(dataSet), .dataWay(dataWay), .dataLine(dataLine),
    .dataBeat(dataBeat), .dataWdata(dataWdata)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                     input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LA_W-1:0] mk(input logic [TAG_W-1:0] t,
                                         input int s, input bit ln);
    return {t, SET_W'(s), ln};
  endfunction

  function automatic logic [BEAT_W-1:0] beatVal(input logic [ADDR_W-1:0] a, input int b);
    return {a, 28'h5A5A5A5, 2'b00, 2'(b)};
  endfunction

  // serve one line burst; entered at a negedge where the request should be up
  task automatic serveLine(input int s, input bit way, input bit ln,
                           input logic [TAG_W-1:0] t, input bit sh);
    logic [ADDR_W-1:0] ea;
    ea = {t, SET_W'(s), ln, 5'b0};
    chk(64'(memReqValid), 64'd1, "R5", "request raised");
    chk(64'(memReqAddr), 64'(ea), "R5", "request address");
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(64'(memReqValid), 64'd1, "R5", "request held");
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    for (int b = 0; b < 4; b++) begin
      memBeatValid = 1'b0;
      repeat ($urandom_range(0, 1)) begin
        #1;
        chk(64'(dataWe), 64'd0, "R5", "no write in gap");
        chk(64'(reqReady), 64'd0, "R6", "busy during fill");
        @(negedge clk);
      end
      memBeatValid = 1'b1;
      memBeatData  = beatVal(ea, b);
      memShared    = (b == 3) ? sh : 1'($urandom);
      #1;
      chk(64'(dataWe), 64'd1, "R5", "write strobe");
      chk(64'(dataSet), 64'(s), "R5", "write set");
      chk(64'(dataWay), 64'(way), "R5", "write way");
      chk(64'(dataLine), 64'(ln), "R5", "write line");
      chk(64'(dataBeat), 64'(b), "R5", "write beat");
      chk(dataWdata, beatVal(ea, b), "R5", "write data");
      chk(64'(reqReady), 64'd0, "R6", "busy during beat");
      @(negedge clk);
    end
    memBeatValid = 1'b0;
    memShared    = 1'b0;
  endtask

  task automatic doAccess(input logic [LA_W-1:0] la, input bit pf,
                          input bit sh0, input bit sh1, input string lbl);
    int s;
    bit ln, way, live;
    int mw;
    logic [TAG_W-1:0] t;
    logic [1:0] expKind, expSt;
    s  = int'(la[SET_W:1]);
    ln = la[0];
    t  = la[LA_W-1 -: TAG_W];
    mw = -1;
    for (int w = 0; w < 2; w++) begin
      live = (mSt[s][w][0] != 2'd0) || (mSt[s][w][1] != 2'd0);
      if (live && mTag[s][w] == t) mw = w;
    end
    if (mw >= 0 && mSt[s][mw][ln] != 2'd0) begin
      expKind = 2'd0; way = 1'(mw); expSt = mSt[s][mw][ln];
    end else if (mw >= 0) begin
      expKind = 2'd2; way = 1'(mw); expSt = 2'd0;
    end else begin
      expKind = 2'd1; way = mLru[s]; expSt = 2'd0;
    end
    chk(64'(reqReady), 64'd1, "R11", "idle before request");
    reqLineAddr = la;
    reqPrefetch = pf;
    reqValid    = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(64'(respValid), 64'd1, "R11", "report after accept");
    chk(64'(respKind), 64'(expKind), lbl, "kind");
    chk(64'(respWay), 64'(way), (expKind == 2'd1) ? "R10" : lbl, "way");
    chk(64'(respState), 64'(expSt), lbl, "prior state");
    if (expKind == 2'd0) begin
      mLru[s] = ~way;
      @(negedge clk);
      chk(64'(reqReady), 64'd1, "R11", "idle after hit");
      chk(64'(memReqValid), 64'd0, "R2", "no request on hit");
      return;
    end
    if (expKind == 2'd1) begin
      mTag[s][way] = t;
      mSt[s][way][0] = 2'd0;
      mSt[s][way][1] = 2'd0;
    end
    @(negedge clk);
    serveLine(s, way, ln, t, sh0);
    mSt[s][way][ln] = sh0 ? 2'd1 : 2'd2;
    mLru[s] = ~way;
    if (pf && mSt[s][way][~ln] == 2'd0) begin
      chk(64'(memReqValid), 64'd1, "R8", "prefetch back to back");
      serveLine(s, way, ~ln, t, sh1);
      mSt[s][way][~ln] = sh1 ? 2'd1 : 2'd2;
      mLru[s] = ~way;
    end else begin
      chk(64'(memReqValid), 64'd0, "R9", "no second request");
    end
    chk(64'(reqReady), 64'd1, "R11", "idle after fill");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TAG_W-1:0] t1, t2, t3;
    logic [TAG_W-1:0] pool [3];
    void'($urandom(32'h1F2E3D4C));
    for (int s = 0; s < SETS; s++) begin
      mLru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        mTag[s][w] = '0; mSt[s][w][0] = 2'd0; mSt[s][w][1] = 2'd0;
      end
    end
    t1 = TAG_W'(22'h00ABC); t2 = TAG_W'(22'h12345); t3 = TAG_W'(22'h3F00F);
    pool[0] = t1; pool[1] = t2; pool[2] = t3;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(64'(reqReady), 64'd1, "R1", "ready after reset");
    chk(64'(respValid), 64'd0, "R1", "no report after reset");
    chk(64'(memReqValid), 64'd0, "R1", "no request after reset");

    doAccess(mk(t1, 0, 0), 1'b0, 1'b0, 1'b0, "R1");   // miss into way 0
    doAccess(mk(t1, 0, 0), 1'b0, 1'b0, 1'b0, "R6");   // hit, Exclusive
    doAccess(mk(t1, 0, 1), 1'b0, 1'b1, 1'b0, "R3");   // other line was cleared
    doAccess(mk(t1, 0, 0), 1'b0, 1'b0, 1'b0, "R4");   // neighbour kept E
    doAccess(mk(t1, 0, 1), 1'b0, 1'b0, 1'b0, "R7");   // filled as Shared
    doAccess(mk(t2, 0, 0), 1'b1, 1'b0, 1'b1, "R10");  // victim way 1, prefetch
    doAccess(mk(t2, 0, 1), 1'b0, 1'b0, 1'b0, "R8");   // prefetched line hits S
    doAccess(mk(t3, 0, 1), 1'b1, 1'b1, 1'b0, "R10");  // victim way 0
    doAccess(mk(t3, 0, 0), 1'b0, 1'b0, 1'b0, "R8");
    doAccess(mk(t1, 1, 0), 1'b0, 1'b0, 1'b0, "R2");
    doAccess(mk(t1, 1, 1), 1'b1, 1'b0, 1'b0, "R9");   // neighbour valid: skip
    doAccess(mk(t1, 1, 0), 1'b0, 1'b0, 1'b0, "R4");

    for (int i = 0; i < 400; i++) begin
      doAccess(mk(pool[$urandom_range(0, 2)], $urandom_range(0, 3), 1'($urandom)),
               1'($urandom), 1'($urandom), 1'($urandom), "R2");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule